// File: doc/BRIEF.md
# Late-Parity Command Checker with Stretched Error Flag

This block checks the integrity of a registered command/address path in which the parity bit does not arrive with the data. The parity bit arrives one clock after the data. When a command is captured, the block reduces the 22 captured bits to a single even-parity syndrome and holds it. On the next clock it samples the late parity pin and compares the two. A mismatch is reported only when the bits were really captured in that command cycle. The report is an active-low flag that stays asserted for two clock cycles, which gives a slow controller time to see it.

The flag is an open-drain line. The block does not drive a level. It produces a pull-down enable, and the board-level pull-up supplies the inactive high level. While reset is asserted, the enable is released. For three clocks after reset is removed, no error can be raised. A mismatch found while a pulse is in progress restarts the two-cycle window from that detection.

Top module: `late_parity_checker`

## Requirements
- R1: Parity is even. A command captured with data `D` has a parity error when XOR of all bits of `D` XOR the parity bit equals 1. When this XOR is 0, no error is raised.
- R2: The parity bit for a command captured at clock edge k is sampled from `parIn` at edge k+1. When an error is found at that edge, `errDriveLow` is 1 in the cycle right after edge k+1.
- R3: A single detection holds `errDriveLow` at 1 for exactly two consecutive cycles. It then returns to 0.
- R4: The parity bit is compared only if `cmdCapture` was 1 at the previous edge. Without a capture, a wrong value on `parIn` leaves `errDriveLow` at 0.
- R5: A detection while the pulse is active restarts the window. `errDriveLow` then stays 1 for two cycles counted from the newest detection.
- R6: While `rstN` is 0, `errDriveLow` is 0 (the line floats high), even if reset arrives in the middle of a pulse.
- R7: After `rstN` rises, no detection is made at the first three clock edges, so `errDriveLow` stays 0 for those three cycles. A mismatch evaluated at the fourth edge is reported normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCapture | input | 1 | High when the command register captures `cmdData` at this edge (valid command cycle) |
| cmdData | input | DATA_WIDTH (22) | Command/address bits being captured |
| parIn | input | 1 | Parity bit, one cycle behind the data it covers |
| errDriveLow | output | 1 | Pull-down enable of the open-drain error line; 1 pulls the line low |

## Verification
The assertions assume that `parIn` always belongs to the capture one edge earlier. They also assume that any pulse longer than two cycles can only come from a fresh detection at an intermediate edge. To stay within these assumptions, the stimulus changes data, capture and parity only on the falling clock edge. Each parity value is placed in the row after its data, so every expected value follows from the alignment rule. The reset-window assertion counts edges from reset release on its own. For this reason the directed reset tests release `rstN` on a falling edge and schedule a bad parity at the second, third and fourth edges after release, which covers both sides of the window.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic loadSyn;    // capture the data syndrome of the current command
    logic compareEn;  // compare the held syndrome with the late parity bit
  } lpcStrobes_t;

endpackage

// File: rtl/lpc_datapath.sv
module lpc_datapath
  import lpc_pkg::*;
#(
  parameter int DATA_WIDTH = 22,
  parameter int LANE_WIDTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_WIDTH-1:0] cmdData,
  input  logic                  parIn,
  input  lpcStrobes_t           strobes,
  output logic                  mismatch
);

  localparam int NUM_LANES = (DATA_WIDTH + LANE_WIDTH - 1) / LANE_WIDTH;

  logic [NUM_LANES-1:0] lanePar;
  logic                 dataPar;
  logic                 synQ;

  // First level of the reduction tree: one partial parity per lane,
  // the last lane may be narrower than the others.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LO  = g * LANE_WIDTH;
    localparam int CNT = (DATA_WIDTH - LO < LANE_WIDTH) ? (DATA_WIDTH - LO) : LANE_WIDTH;
    assign lanePar[g] = ^cmdData[LO +: CNT];
  end

  assign dataPar = ^lanePar;

  // Only the one-bit syndrome is kept, not the 22 data bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synQ <= 1'b0;
    end else if (strobes.loadSyn) begin
      synQ <= dataPar;
    end
  end

  // Even parity: syndrome of data XOR received bit must be zero.
  assign mismatch = strobes.compareEn & (synQ ^ parIn);

endmodule

// File: rtl/lpc_control.sv
module lpc_control
  import lpc_pkg::*;
#(
  parameter int PULSE_CYCLES = 2,
  parameter int HOLD_CYCLES  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdCapture,
  input  logic        mismatch,
  output lpcStrobes_t strobes,
  output logic        errDriveLow
);

  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam int HOLD_W  = $clog2(HOLD_CYCLES + 1);

  logic               validQ;
  logic [HOLD_W-1:0]  holdCnt;
  logic [PULSE_W-1:0] pulseCnt;

  // Remembers that the previous edge captured a command.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else begin
      validQ <= cmdCapture;
    end
  end

  // Post-reset quiet window: detections are suppressed until it expires.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= HOLD_W'(HOLD_CYCLES);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // Pulse stretcher; a new detection reloads the full width.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (mismatch) begin
      pulseCnt <= PULSE_W'(PULSE_CYCLES);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.loadSyn   = cmdCapture;
    strobes.compareEn = validQ && (holdCnt == '0);
  end

  assign errDriveLow = (pulseCnt != '0);

endmodule

// File: rtl/late_parity_checker.sv
module late_parity_checker
  import lpc_pkg::*;
#(
  parameter int DATA_WIDTH   = 22,
  parameter int LANE_WIDTH   = 4,
  parameter int PULSE_CYCLES = 2,
  parameter int HOLD_CYCLES  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdCapture,
  input  logic [DATA_WIDTH-1:0] cmdData,
  input  logic                  parIn,
  output logic                  errDriveLow
);

  lpcStrobes_t strobes;
  logic        mismatch;

  lpc_datapath #(
    .DATA_WIDTH (DATA_WIDTH),
    .LANE_WIDTH (LANE_WIDTH)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmdData  (cmdData),
    .parIn    (parIn),
    .strobes  (strobes),
    .mismatch (mismatch)
  );

  lpc_control #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .HOLD_CYCLES  (HOLD_CYCLES)
  ) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .cmdCapture  (cmdCapture),
    .mismatch    (mismatch),
    .strobes     (strobes),
    .errDriveLow (errDriveLow)
  );

endmodule

// File: rtl/late_parity_checker_chk.sv
module late_parity_checker_chk #(
  parameter int HOLD_CYCLES = 3
) (
  input logic clk,
  input logic rstN,
  input logic cmdCapture,
  input logic mismatch,
  input logic errDriveLow
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 2);

  logic [CNT_W-1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst <= CNT_W'(HOLD_CYCLES)) begin
      sinceRst <= sinceRst + 1'b1;
    end
  end

  // R2
  detect_to_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> errDriveLow);

  // R3
  pulse_min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errDriveLow) |=> errDriveLow);

  // R3
  pulse_max_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mismatch && !$past(mismatch)) |=> !errDriveLow);

  // R4
  valid_cycle_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmdCapture) |-> !mismatch);

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst <= CNT_W'(HOLD_CYCLES)) |-> !errDriveLow);

endmodule

bind late_parity_checker late_parity_checker_chk #(
  .HOLD_CYCLES (HOLD_CYCLES)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdCapture  (cmdCapture),
  .mismatch    (mismatch),
  .errDriveLow (errDriveLow)
);

// File: tb/test_late_parity_checker.sv
`timescale 1ns/1ps
module test_late_parity_checker;

  localparam int DW = 22;
  localparam int NV = 28;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdCapture = 1'b0;
  logic [DW-1:0] cmdData = '0;
  logic          parIn = 1'b0;
  logic          errDriveLow;
  logic          errLine;

  int nChecks = 0;
  int nFails  = 0;

  // Pull-up resolution of the open-drain line.
  assign errLine = errDriveLow ? 1'b0 : 1'b1;

  always #2 clk = ~clk;

  late_parity_checker i_late_parity_checker (
    .clk         (clk),
    .rstN        (rstN),
    .cmdCapture  (cmdCapture),
    .cmdData     (cmdData),
    .parIn       (parIn),
    .errDriveLow (errDriveLow)
  );

  // {capture, data, parity for previous row's data, expected line low after this edge}
  localparam logic [DW+2:0] VEC [NV] = '{
    {1'b1, 22'h000001, 1'b0, 1'b0},  // 0
    {1'b0, 22'h000000, 1'b1, 1'b0},  // 1  R1 correct odd parity
    {1'b1, 22'h000001, 1'b0, 1'b0},  // 2
    {1'b0, 22'h000000, 1'b0, 1'b1},  // 3  R2 bad parity, flag next cycle
    {1'b0, 22'h000000, 1'b0, 1'b1},  // 4  R3 second cycle
    {1'b0, 22'h000000, 1'b0, 1'b0},  // 5  R3 released
    {1'b0, 22'h000001, 1'b0, 1'b0},  // 6  no capture
    {1'b0, 22'h000000, 1'b1, 1'b0},  // 7  R4 wrong bit ignored
    {1'b1, 22'h3FFFFF, 1'b0, 1'b0},  // 8
    {1'b1, 22'h000003, 1'b1, 1'b1},  // 9  R1 all ones is even -> bad
    {1'b1, 22'h000001, 1'b1, 1'b1},  // 10 R5 restart
    {1'b0, 22'h000000, 1'b0, 1'b1},  // 11 R5 restart again
    {1'b0, 22'h000000, 1'b0, 1'b1},  // 12 R5 tail
    {1'b0, 22'h000000, 1'b0, 1'b0},  // 13
    {1'b1, 22'h2AAAAA, 1'b0, 1'b0},  // 14
    {1'b0, 22'h000000, 1'b1, 1'b0},  // 15 R1 eleven ones, correct
    {1'b0, 22'h000000, 1'b0, 1'b0},  // 16
    {1'b1, 22'h3FFFFF, 1'b0, 1'b0},  // 17
    {1'b1, 22'h000001, 1'b0, 1'b0},  // 18 R2 back-to-back, correct
    {1'b0, 22'h000000, 1'b1, 1'b0},  // 19
    {1'b0, 22'h000000, 1'b0, 1'b0},  // 20
    {1'b1, 22'h200000, 1'b0, 1'b0},  // 21 top bit of narrow lane
    {1'b0, 22'h000000, 1'b0, 1'b1},  // 22 R1 bad
    {1'b0, 22'h000000, 1'b0, 1'b1},  // 23 R3
    {1'b0, 22'h000000, 1'b0, 1'b0},  // 24
    {1'b1, 22'h200000, 1'b0, 1'b0},  // 25
    {1'b0, 22'h000000, 1'b1, 1'b0},  // 26 R1 correct
    {1'b0, 22'h000000, 1'b0, 1'b0}   // 27
  };

  task automatic check(input logic expLow, input string tag);
    nChecks++;
    if (errLine !== ~expLow) begin
      nFails++;
      $display("FAIL %s: line=%b expected=%b at %0t", tag, errLine, ~expLow, $time);
    end
  endtask

  // Called at a falling edge; drives, waits for the rising edge, then checks.
  task automatic step(input logic cap, input logic [DW-1:0] d, input logic p,
                      input logic expLow, input string tag);
    cmdCapture = cap;
    cmdData    = d;
    parIn      = p;
    @(posedge clk);
    #1;
    check(expLow, tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R6 reset state
    repeat (3) @(negedge clk);
    check(1'b0, "R6 during reset");
    rstN = 1'b1;
    // R7 quiet window
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b0, "R7 idle");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][DW+2], VEC[i][DW+1:2], VEC[i][1], VEC[i][0],
           $sformatf("R1 R2 R3 R4 R5 vector %0d", i));
    end

    // R6: reset in the middle of a pulse releases the line at once
    step(1'b1, 22'h000001, 1'b0, 1'b0, "R6 setup");
    step(1'b0, 22'h000000, 1'b0, 1'b1, "R6 pulse started");
    #1 rstN = 1'b0;
    #0.5;
    check(1'b0, "R6 async release");
    @(negedge clk);
    check(1'b0, "R6 held in reset");

    // R7: bad parity at edges 2 and 3 after release is suppressed, at edge 4 reported
    rstN = 1'b1;
    step(1'b1, 22'h000001, 1'b0, 1'b0, "R7 edge1");
    step(1'b1, 22'h000001, 1'b0, 1'b0, "R7 edge2");
    step(1'b1, 22'h000001, 1'b0, 1'b0, "R7 edge3");
    step(1'b0, 22'h000000, 1'b0, 1'b1, "R7 edge4 reported");
    step(1'b0, 22'h000000, 1'b1, 1'b1, "R7 R3 second cycle");
    step(1'b0, 22'h000000, 1'b0, 1'b0, "R3 released");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule